// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a synchronous bus write port and the control logic of a 512K x 8 nonvolatile memory model. It erases by 256-byte sector and programs one byte at a time. Each bus write is decoded into one of a small set of byte-wide commands. Erase and program use two writes: a setup write arms the operation and an execute write launches it. The block issues a one-cycle start pulse together with the target address and data. A reset command drops any armed or running operation and raises an abort pulse. A separate command switches the read path from the array to the identification codes.

A protect detector outside this block supplies the software write-protect flag. The array timer outside this block reports completion on `op_done`. Every output is registered, so a result appears in the cycle after the clock edge that samples the write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all three pulse outputs are low, `id_sel` is 0 (array read) and no operation is running.
- R2: A write of 20h followed by a write of D0h, with protection off, pulses `erase_start` one cycle after the second write. `op_addr` then holds address bits 18..8 of that write with bits 7..0 forced to zero, and `op_data` holds FFh.
- R3: A write of 10h followed by any write whose data is not FFh, with protection off, pulses `prog_start` one cycle later. `op_addr` and `op_data` then hold that write's full address and data.
- R4: A write of FFh in any state pulses `abort` one cycle later, returns to array read (`id_sel` 0) and ends any armed or running operation, without a start pulse.
- R5: A write of 90h sets `id_sel` to 1 (1 selects ID codes, 0 selects the array). The writes 20h, 10h and FFh clear it. Any other data leaves it set.
- R6: With `prot_on` high at the setup write or at the execute write, no start pulse is issued and the block returns to array read. 90h and FFh act normally while `prot_on` is high.
- R7: After 20h, any data other than D0h or FFh discards the setup without a pulse. A later lone D0h starts nothing.
- R8: From a start pulse until `op_done` or an FFh write, every write other than FFh is ignored: no setup, no start and no change of `id_sel`.
- R9: Each start or abort pulse lasts exactly one cycle, and at most one of `erase_start`, `prog_start` and `abort` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data / command byte |
| prot_on | input | 1 | Software write protection active |
| op_done | input | 1 | Running erase or program has finished |
| erase_start | output | 1 | One-cycle sector erase launch |
| prog_start | output | 1 | One-cycle byte program launch |
| abort | output | 1 | One-cycle abort of armed/running operation |
| op_addr | output | 19 | Sector-aligned or byte address of the last launch |
| op_data | output | 8 | Data byte of the last launch (FFh for erase) |
| id_sel | output | 1 | Read path select: 1 ID codes, 0 array |

## Verification
The bench sends every data value as the second write after an erase setup, and every value as a first write from array mode followed by a fixed probe byte. A decoder that accepts the wrong execute byte, fails to drop a stale setup, or lets an unrelated byte leave identification mode shows up as a stray or missing pulse, or as a wrong `id_sel`. Directed cases cover protection raised between setup and execute, setup bytes sent while an operation is running, and an abort during a run followed by a fresh program. A design that checks protection only at setup, keeps decoding while busy, or fails to clear the busy state on reset would pulse a start where none is allowed, or would block the next program.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_ERASE_ARM = 8'h20;
    localparam logic [BYTE_W-1:0] CODE_ERASE_GO  = 8'hD0;
    localparam logic [BYTE_W-1:0] CODE_PROG_ARM  = 8'h10;
    localparam logic [BYTE_W-1:0] CODE_IDENT     = 8'h90;
    localparam logic [BYTE_W-1:0] CODE_RESET     = 8'hFF;
    localparam logic [BYTE_W-1:0] ERASED_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        MD_ARRAY,
        MD_ERASE_ARMED,
        MD_PROG_ARMED,
        MD_IDENT
    } mode_e;

    typedef enum logic [2:0] {
        CMD_OTHER,
        CMD_ERASE_ARM,
        CMD_ERASE_GO,
        CMD_PROG_ARM,
        CMD_IDENT,
        CMD_RESET
    } cmd_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TO_ARRAY,
        ACT_ARM_ERASE,
        ACT_ARM_PROG,
        ACT_ENTER_ID,
        ACT_ABORT,
        ACT_GO_ERASE,
        ACT_GO_PROG
    } act_e;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import flash_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output cmd_e              cmd
);
    always_comb begin
        unique case (byte_in)
            CODE_ERASE_ARM: cmd = CMD_ERASE_ARM;
            CODE_ERASE_GO:  cmd = CMD_ERASE_GO;
            CODE_PROG_ARM:  cmd = CMD_PROG_ARM;
            CODE_IDENT:     cmd = CMD_IDENT;
            CODE_RESET:     cmd = CMD_RESET;
            default:        cmd = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/fcs_policy.sv
module fcs_policy
    import flash_cmd_pkg::*;
(
    input  logic  wr_en,
    input  cmd_e  cmd,
    input  mode_e mode,
    input  logic  busy,
    input  logic  prot_on,
    output act_e  act
);
    always_comb begin
        act = ACT_NONE;
        if (wr_en) begin
            if (cmd == CMD_RESET) begin
                act = ACT_ABORT;
            end else if (!busy) begin
                unique case (mode)
                    MD_ERASE_ARMED: begin
                        act = (cmd == CMD_ERASE_GO && !prot_on) ? ACT_GO_ERASE : ACT_TO_ARRAY;
                    end
                    MD_PROG_ARMED: begin
                        act = prot_on ? ACT_TO_ARRAY : ACT_GO_PROG;
                    end
                    default: begin
                        unique case (cmd)
                            CMD_ERASE_ARM: act = prot_on ? ACT_TO_ARRAY : ACT_ARM_ERASE;
                            CMD_PROG_ARM:  act = prot_on ? ACT_TO_ARRAY : ACT_ARM_PROG;
                            CMD_IDENT:     act = ACT_ENTER_ID;
                            default:       act = ACT_NONE;
                        endcase
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SECT_OFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              prot_on,
    input  logic              op_done,
    output logic              erase_start,
    output logic              prog_start,
    output logic              abort,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTE_W-1:0] op_data,
    output logic              id_sel
);
    localparam int SECT_W = ADDR_W - SECT_OFS_W;

    typedef struct packed {
        mode_e             mode;
        logic              busy;
        logic              erase_go;
        logic              prog_go;
        logic              abort;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;
    cmd_e cmd;
    act_e act;

    fcs_decode i_decode (
        .byte_in (wr_data),
        .cmd     (cmd)
    );

    fcs_policy i_policy (
        .wr_en   (wr_en),
        .cmd     (cmd),
        .mode    (seq_q.mode),
        .busy    (seq_q.busy),
        .prot_on (prot_on),
        .act     (act)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.erase_go = 1'b0;
        seq_d.prog_go  = 1'b0;
        seq_d.abort    = 1'b0;
        if (seq_q.busy && op_done) begin
            seq_d.busy = 1'b0;
        end
        unique case (act)
            ACT_TO_ARRAY:  seq_d.mode = MD_ARRAY;
            ACT_ARM_ERASE: seq_d.mode = MD_ERASE_ARMED;
            ACT_ARM_PROG:  seq_d.mode = MD_PROG_ARMED;
            ACT_ENTER_ID:  seq_d.mode = MD_IDENT;
            ACT_ABORT: begin
                seq_d.mode  = MD_ARRAY;
                seq_d.busy  = 1'b0;
                seq_d.abort = 1'b1;
            end
            ACT_GO_ERASE: begin
                seq_d.mode     = MD_ARRAY;
                seq_d.busy     = 1'b1;
                seq_d.erase_go = 1'b1;
                seq_d.addr     = {wr_addr[ADDR_W-1 -: SECT_W], {SECT_OFS_W{1'b0}}};
                seq_d.data     = ERASED_BYTE;
            end
            ACT_GO_PROG: begin
                seq_d.mode    = MD_ARRAY;
                seq_d.busy    = 1'b1;
                seq_d.prog_go = 1'b1;
                seq_d.addr    = wr_addr;
                seq_d.data    = wr_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign erase_start = seq_q.erase_go;
    assign prog_start  = seq_q.prog_go;
    assign abort       = seq_q.abort;
    assign op_addr     = seq_q.addr;
    assign op_data     = seq_q.data;
    assign id_sel      = (seq_q.mode == MD_IDENT);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int ADDR_W     = 19,
    parameter int SECT_OFS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              prot_on,
    input logic              erase_start,
    input logic              prog_start,
    input logic              abort,
    input logic [ADDR_W-1:0] op_addr,
    input logic              id_sel
);
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_start, prog_start, abort}));

    p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start || prog_start) |=> !(erase_start || prog_start));

    p_erase_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (op_addr[SECT_OFS_W-1:0] == '0));

    p_erase_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_en && wr_data == 8'hD0));

    p_prot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start || prog_start) |-> $past(!prot_on));

    p_abort_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ($past(wr_en && wr_data == 8'hFF) && !id_sel));

    p_id_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_sel) |-> $past(wr_en && wr_data == 8'h90));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .SECT_OFS_W(SECT_OFS_W)) i_fcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .prot_on     (prot_on),
    .erase_start (erase_start),
    .prog_start  (prog_start),
    .abort       (abort),
    .op_addr     (op_addr),
    .id_sel      (id_sel)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prot_on = 1'b0;
    logic        op_done = 1'b0;
    logic        erase_start, prog_start, abort, id_sel;
    logic [18:0] op_addr;
    logic [7:0]  op_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_on(prot_on), .op_done(op_done), .erase_start(erase_start),
        .prog_start(prog_start), .abort(abort), .op_addr(op_addr), .op_data(op_data),
        .id_sel(id_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write; returns at the negedge after the sampling edge
    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pulses {erase_start, prog_start, abort}
    task automatic pulses(input string req, input logic [2:0] exp);
        chk(req, {29'd0, erase_start, prog_start, abort}, {29'd0, exp});
    endtask

    task automatic finish_op;
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        pulses("R1", 3'b000);
        chk("R1 id_sel", id_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulses("R1", 3'b000);

        // R2/R4/R7 sweep of the byte after erase setup
        for (int v = 0; v < 256; v++) begin
            logic [18:0] a;
            a = {v[2:0], v[7:0], ~v[7:0]};
            wr(19'h0, 8'h20);
            pulses("R2 setup quiet", 3'b000);
            wr(a, v[7:0]);
            if (v == 8'hD0) begin
                pulses("R2 erase go", 3'b100);
                chk("R2 op_addr", op_addr, {a[18:8], 8'h00});
                chk("R2 op_data", op_data, 8'hFF);
                @(negedge clk);
                pulses("R9 width", 3'b000);
                finish_op();
            end else if (v == 8'hFF) begin
                pulses("R4 abort", 3'b001);
            end else begin
                pulses("R7 discard", 3'b000);
            end
            wr(19'h0, 8'hD0);
            pulses("R7 lone D0", 3'b000);
        end

        // R3/R5 sweep of the first byte from array mode, probed with 33h
        for (int v = 0; v < 256; v++) begin
            wr(19'h0, v[7:0]);
            chk("R5 id_sel", id_sel, (v == 8'h90));
            pulses("R4/R5 first", (v == 8'hFF) ? 3'b001 : 3'b000);
            wr({v[2:0], 16'hA55A}, 8'h33);
            if (v == 8'h10) begin
                pulses("R3 prog go", 3'b010);
                chk("R3 op_addr", op_addr, {v[2:0], 16'hA55A});
                chk("R3 op_data", op_data, 8'h33);
                finish_op();
            end else begin
                pulses("R7/R5 probe", 3'b000);
            end
            chk("R5 id kept", id_sel, (v == 8'h90));
            wr(19'h0, 8'hFF);
            pulses("R4 cleanup", 3'b001);
            chk("R4 id cleared", id_sel, 0);
        end

        // R5 exit via 10h
        wr(0, 8'h90); wr(0, 8'h10);
        chk("R5 leave on 10h", id_sel, 0);
        wr(0, 8'hFF);
        // R3 FF data after program setup aborts
        wr(0, 8'h10); wr(19'h12345, 8'hFF);
        pulses("R3 FF aborts", 3'b001);

        // R6 protection
        prot_on = 1'b1;
        wr(0, 8'h20); wr(19'h100, 8'hD0);
        pulses("R6 erase blocked", 3'b000);
        wr(0, 8'h10); wr(19'h100, 8'h55);
        pulses("R6 prog blocked", 3'b000);
        wr(0, 8'h90);
        chk("R6 id allowed", id_sel, 1);
        wr(0, 8'hFF);
        pulses("R6 reset allowed", 3'b001);
        prot_on = 1'b0;
        wr(0, 8'h10);
        prot_on = 1'b1;
        wr(19'h200, 8'h66);
        pulses("R6 raised before execute", 3'b000);
        prot_on = 1'b0;
        wr(19'h200, 8'hD0);
        pulses("R6 back to array", 3'b000);

        // R8 busy
        wr(0, 8'h20); wr(19'h7FF00, 8'hD0);
        pulses("R8 start", 3'b100);
        wr(0, 8'h10); wr(19'h1, 8'h44);
        pulses("R8 prog ignored", 3'b000);
        wr(0, 8'h90);
        chk("R8 id ignored", id_sel, 0);
        wr(0, 8'hFF);
        pulses("R8 abort running", 3'b001);
        wr(0, 8'h10); wr(19'h2, 8'h77);
        pulses("R8 free after abort", 3'b010);
        wr(0, 8'h20); wr(0, 8'hD0);
        pulses("R8 busy after prog", 3'b000);
        finish_op();
        wr(0, 8'h90);
        chk("R8 free after done", id_sel, 1);
        wr(0, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule